// File: doc/BRIEF.md
# Line and Field Enable Generator

This block produces the window signals that control a pair of field memories in a scan-converting video path. A horizontal position counter runs on the pixel clock and returns to zero on every horizontal reference pulse. A line counter advances once per reference pulse and returns to zero when vertical sync rises. Each output window is set by a programmable start position and a programmable stop position. Comparators on the two counters turn these positions into three outputs:

- a horizontal blanking signal, HIGH while valid memory data is present;
- a composite read enable, which is the horizontal read window ANDed with the vertical window;
- a vertical blanking signal.

The horizontal positions are 11 bits wide. The low 8 bits of each position come from its own input. The high bits of all four horizontal positions come packed in one shared input. A 2-bit delay select retimes the blanking and read-enable outputs by 0 to 3 extra clocks, so that they line up with downstream display processing. All outputs leave the block from registers.

Top module: `fmw_window_gen`

## Requirements
- R1: While `rst_n` is low, `hblank_n` = 0, `rd_en` = 0 and `vblank_n` = 1.
- R2: The horizontal count is 0 in the cycle after a cycle with `href` high, and otherwise rises by one each cycle. `hblank_n` is HIGH exactly when the count lies in [start, stop), where start and stop are the two blanking positions.
- R3: The line count becomes 0 in the cycle after a cycle in which `vsync` goes from 0 to 1. Otherwise it rises by one after each cycle with `href` high. A rising edge wins over `href` when both occur in the same cycle. `vblank_n` is LOW exactly when the line count lies in the vertical window [`vwin_start`, `vwin_stop`).
- R4: A horizontal position is formed as high-bits × 256 + low byte. The 12-bit `pos_hi` input supplies the high bits, 3 bits per position: bits [2:0] for blank start, [5:3] for blank stop, [8:6] for read start and [11:9] for read stop.
- R5: When a start position equals its stop position, that window is never active.
- R6: When start is greater than stop, the window wraps. It is active when the count is ≥ start or < stop.
- R7: With `dly_sel` = d, `hblank_n` and `rd_en` in a cycle reflect the counts of 2+d cycles earlier. `vblank_n` always reflects the line count of 2 cycles earlier, whatever the value of d.
- R8: `rd_en` is HIGH exactly when the horizontal read window and the vertical window are both active.
- R9: The horizontal count holds at 2047 when no `href` arrives. It does not wrap, so a window that covers 2047 stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| href | input | 1 | Horizontal reference pulse, one clock wide |
| vsync | input | 1 | Vertical sync level; its rising edge restarts the line count |
| blank_start_lo | input | 8 | Low byte of the position where the blanking window starts |
| blank_stop_lo | input | 8 | Low byte of the position where the blanking window stops |
| read_start_lo | input | 8 | Low byte of the position where the horizontal read window starts |
| read_stop_lo | input | 8 | Low byte of the position where the horizontal read window stops |
| pos_hi | input | 12 | Packed high bits of the four horizontal positions |
| vwin_start | input | 10 | First line of the vertical window |
| vwin_stop | input | 10 | Line at which the vertical window ends |
| dly_sel | input | 2 | Extra delay, 0 to 3 clocks, for `hblank_n` and `rd_en` |
| hblank_n | output | 1 | Horizontal blanking: LOW = blank, HIGH = valid data |
| rd_en | output | 1 | Composite read enable, HIGH = read allowed |
| vblank_n | output | 1 | Vertical blanking: LOW inside the vertical window |

## Verification
A horizontal count that restarts or steps wrongly moves the edges of `hblank_n` and `rd_en` within two cycles of the line reference. This shows up on the very next line. A wrong line count or a missed sync edge shifts `vblank_n` and gates `rd_en` at the wrong lines. It appears within the first few lines of the field. A wrong tap in the delay line shifts both horizontal outputs by whole cycles at every window edge, while `vblank_n` stays put. A comparator with a wrong relation shows up only on equal or wrapped settings, so those settings are driven directly.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

  localparam int CALC_W = 16;

  typedef logic [CALC_W-1:0] calc_t;

  // Window membership: half-open [start, stop), wrapping when start > stop,
  // empty when start == stop.
  function automatic logic win_hit(input calc_t cnt, input calc_t start, input calc_t stop);
    logic r;
    if (start == stop)
      r = 1'b0;
    else if (start < stop)
      r = (cnt >= start) && (cnt < stop);
    else
      r = (cnt >= start) || (cnt < stop);
    return r;
  endfunction

  // Join a high-bit field and a low byte into one position.
  function automatic calc_t join_pos(input calc_t hi, input calc_t lo, input int lo_w);
    return (hi << lo_w) | lo;
  endfunction

  typedef struct packed {
    logic blank;
    logic read;
  } htap_t;

endpackage

// File: rtl/fmw_sat_counter.sv
module fmw_sat_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (step && !at_max)
      cnt <= cnt + 1'b1;
  end

  // R2 / R3: a restart always lands on zero
  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R2: a plain step advances by exactly one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && step && !at_max) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R9: the top value is held, never wrapped
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && at_max) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/fmw_win_cmp.sv
module fmw_win_cmp #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] start,
  input  logic [W-1:0] stop,
  output logic         hit_q
);
  import fmw_pkg::*;

  logic hit_now;
  assign hit_now = win_hit(calc_t'(cnt), calc_t'(start), calc_t'(stop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hit_q <= 1'b0;
    else
      hit_q <= hit_now;
  end

  // R5: equal start and stop never opens the window
  assert_empty_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start == stop) |=> !hit_q);

endmodule

// File: rtl/fmw_tap_delay.sv
module fmw_tap_delay #(
  parameter int W     = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = (1 << SEL_W) - 1;

  logic [W-1:0] stage [DEPTH];
  logic [W-1:0] taps  [DEPTH+1];

  assign taps[0] = din;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage[g] <= '0;
      else if (g == 0)
        stage[g] <= din;
      else
        stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
    assign taps[g+1] = stage[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dout <= '0;
    else
      dout <= taps[sel];
  end

  // R7: no extra delay passes the input after one register
  assert_zero_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> (dout == $past(din)));

  // R7: one extra clock of delay
  assert_one_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_W'(1)) |=> (dout == $past(din, 2)));

endmodule

// File: rtl/fmw_window_gen.sv
module fmw_window_gen #(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10,
  parameter int LO_W   = 8,
  parameter int DLY_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          href,
  input  logic                          vsync,
  input  logic [LO_W-1:0]               blank_start_lo,
  input  logic [LO_W-1:0]               blank_stop_lo,
  input  logic [LO_W-1:0]               read_start_lo,
  input  logic [LO_W-1:0]               read_stop_lo,
  input  logic [4*(HCNT_W-LO_W)-1:0]    pos_hi,
  input  logic [VCNT_W-1:0]             vwin_start,
  input  logic [VCNT_W-1:0]             vwin_stop,
  input  logic [DLY_W-1:0]              dly_sel,
  output logic                          hblank_n,
  output logic                          rd_en,
  output logic                          vblank_n
);
  import fmw_pkg::*;

  localparam int HI_W = HCNT_W - LO_W;

  // Field index in pos_hi for each horizontal position (R4)
  localparam int F_BL_START = 0;
  localparam int F_BL_STOP  = 1;
  localparam int F_RD_START = 2;
  localparam int F_RD_STOP  = 3;

  logic [HCNT_W-1:0] hcnt;
  logic [VCNT_W-1:0] vcnt;
  logic              vs_q;
  logic              vs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vs_q <= 1'b0;
    else
      vs_q <= vsync;
  end
  assign vs_rise = vsync & ~vs_q;

  fmw_sat_counter #(.W(HCNT_W)) u_hcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (href),
    .step    (1'b1),
    .cnt     (hcnt)
  );

  fmw_sat_counter #(.W(VCNT_W)) u_vcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (vs_rise),
    .step    (href),
    .cnt     (vcnt)
  );

  // Full horizontal positions
  logic [HCNT_W-1:0] lo_field [4];
  logic [HCNT_W-1:0] hpos     [4];

  assign lo_field[F_BL_START] = HCNT_W'(blank_start_lo);
  assign lo_field[F_BL_STOP]  = HCNT_W'(blank_stop_lo);
  assign lo_field[F_RD_START] = HCNT_W'(read_start_lo);
  assign lo_field[F_RD_STOP]  = HCNT_W'(read_stop_lo);

  for (genvar f = 0; f < 4; f++) begin : g_pos
    assign hpos[f] = HCNT_W'(join_pos(calc_t'(pos_hi[f*HI_W +: HI_W]),
                                      calc_t'(lo_field[f]), LO_W));
  end

  logic blank_hit_q;
  logic read_hit_q;
  logic vert_hit_q;

  fmw_win_cmp #(.W(HCNT_W)) u_blank_win (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (hcnt),
    .start (hpos[F_BL_START]),
    .stop  (hpos[F_BL_STOP]),
    .hit_q (blank_hit_q)
  );

  fmw_win_cmp #(.W(HCNT_W)) u_read_win (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (hcnt),
    .start (hpos[F_RD_START]),
    .stop  (hpos[F_RD_STOP]),
    .hit_q (read_hit_q)
  );

  fmw_win_cmp #(.W(VCNT_W)) u_vert_win (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (vcnt),
    .start (vwin_start),
    .stop  (vwin_stop),
    .hit_q (vert_hit_q)
  );

  htap_t tap_in;
  htap_t tap_out;

  assign tap_in.blank = blank_hit_q;
  assign tap_in.read  = read_hit_q & vert_hit_q;

  fmw_tap_delay #(.W($bits(htap_t)), .SEL_W(DLY_W)) u_tap (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (dly_sel),
    .din   (tap_in),
    .dout  (tap_out)
  );

  logic vb_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vb_q <= 1'b1;
    else
      vb_q <= ~vert_hit_q;
  end

  assign hblank_n = tap_out.blank;
  assign rd_en    = tap_out.read;
  assign vblank_n = vb_q;

  // R8: a read is never enabled while the vertical window was closed
  assert_read_needs_vwin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == '0 && !vert_hit_q) |=> !rd_en);

endmodule

// File: tb/test_fmw_window_gen.sv
`timescale 1ns/1ps
module test_fmw_window_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       href = 1'b0;
  logic       vsync = 1'b0;
  logic [7:0] blank_start_lo = '0, blank_stop_lo = '0;
  logic [7:0] read_start_lo = '0, read_stop_lo = '0;
  logic [2:0] hi_bs = '0, hi_be = '0, hi_rs = '0, hi_re = '0;
  logic [11:0] pos_hi;
  logic [9:0] vwin_start = '0, vwin_stop = '0;
  logic [1:0] dly_sel = '0;
  logic       hblank_n, rd_en, vblank_n;

  assign pos_hi = {hi_re, hi_rs, hi_be, hi_bs};

  always #10 clk = ~clk;

  fmw_window_gen i_fmw_window_gen (
    .clk(clk), .rst_n(rst_n), .href(href), .vsync(vsync),
    .blank_start_lo(blank_start_lo), .blank_stop_lo(blank_stop_lo),
    .read_start_lo(read_start_lo), .read_stop_lo(read_stop_lo),
    .pos_hi(pos_hi), .vwin_start(vwin_start), .vwin_stop(vwin_stop),
    .dly_sel(dly_sel), .hblank_n(hblank_n), .rd_en(rd_en), .vblank_n(vblank_n)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    chk_on = 1'b0;
  bit    done = 1'b0;

  // Window rule restated: outside when below start or at/after stop, unless wrapping.
  function automatic bit in_win(int c, int s, int e);
    if (s == e) return 1'b0;
    if (s > e)  return !(c < s && c >= e);
    return (c >= s) && (c < e);
  endfunction

  function automatic int full_pos(int hi, int lo);
    return hi * 256 + lo;
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", req, what, $time, act, exp);
    end
  endtask

  // Reference cycle model
  int mh, mv, mdly;
  bit mvsq, rise;
  bit hb [5];
  bit rd [5];
  bit vw [5];

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mvsq = 1'b0;
      for (int i = 0; i < 5; i++) begin hb[i] = 0; rd[i] = 0; vw[i] = 0; end
    end else begin
      for (int i = 4; i > 0; i--) begin hb[i] = hb[i-1]; rd[i] = rd[i-1]; vw[i] = vw[i-1]; end
      hb[0] = in_win(mh, full_pos(hi_bs, blank_start_lo), full_pos(hi_be, blank_stop_lo));
      vw[0] = in_win(mv, vwin_start, vwin_stop);
      rd[0] = in_win(mh, full_pos(hi_rs, read_start_lo), full_pos(hi_re, read_stop_lo)) && vw[0];
      rise = vsync && !mvsq;
      mvsq = vsync;
      if (href) mh = 0; else if (mh != 2047) mh++;
      if (rise) mv = 0; else if (href && mv != 1023) mv++;
    end
    mdly = dly_sel;
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check(hblank_n, hb[1+mdly], tag, "hblank_n");
      check(rd_en, rd[1+mdly], (tag == "R7") ? "R7" : "R8", "rd_en");
      check(vblank_n, !vw[1], "R3", "vblank_n");
    end
  end

  task automatic run_field(int nlines, int len_lo, int len_span);
    for (int l = 0; l < nlines; l++) begin
      int len = len_lo + $urandom_range(len_span);
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        href  = (c == 0);
        vsync = (l < 2);
      end
    end
  endtask

  task automatic rand_low_h();
    hi_bs = 0; hi_be = 0; hi_rs = 0; hi_re = 0;
    blank_start_lo = 8'($urandom_range(40, 10));
    blank_stop_lo  = 8'($urandom_range(95, 50));
    read_start_lo  = 8'($urandom_range(30, 5));
    read_stop_lo   = 8'($urandom_range(90, 45));
    vwin_start     = 10'($urandom_range(5, 2));
    vwin_stop      = 10'($urandom_range(13, 8));
  endtask

  initial begin
    int unsigned seed_init = $urandom(32'd20240611);
    if (seed_init == 0) $display("seeded");
    // R1: reset state
    repeat (3) @(negedge clk);
    check(hblank_n, 1'b0, "R1", "hblank_n in reset");
    check(rd_en,    1'b0, "R1", "rd_en in reset");
    check(vblank_n, 1'b1, "R1", "vblank_n in reset");
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R2: basic windows, random settings
    tag = "R2";
    for (int k = 0; k < 4; k++) begin
      rand_low_h();
      run_field(16, 100, 60);
      run_field(16, 100, 60);
    end

    // R4: positions above 255 use the packed high bits
    tag = "R4";
    for (int k = 0; k < 2; k++) begin
      hi_bs = 3'($urandom_range(1, 0)); blank_start_lo = 8'($urandom);
      hi_be = 3'($urandom_range(2, 2)); blank_stop_lo  = 8'($urandom);
      hi_rs = 3'($urandom_range(1, 1)); read_start_lo  = 8'($urandom);
      hi_re = 3'($urandom_range(2, 2)); read_stop_lo   = 8'($urandom);
      vwin_start = 10'd1; vwin_stop = 10'd6;
      run_field(8, 700, 0);
    end

    // R5: equal start and stop gives no window
    tag = "R5";
    hi_bs = 0; hi_be = 0; hi_rs = 0; hi_re = 0;
    blank_start_lo = 8'd30; blank_stop_lo = 8'd30;
    read_start_lo  = 8'd0;  read_stop_lo  = 8'd0;
    vwin_start = 10'd4; vwin_stop = 10'd4;
    run_field(12, 80, 20);

    // R6: start after stop wraps around the line and the field
    tag = "R6";
    blank_start_lo = 8'($urandom_range(120, 80)); blank_stop_lo = 8'($urandom_range(40, 10));
    read_start_lo  = 8'($urandom_range(110, 70)); read_stop_lo  = 8'($urandom_range(30, 5));
    vwin_start = 10'd12; vwin_stop = 10'd3;
    run_field(16, 140, 40);
    run_field(16, 140, 40);

    // R7: every delay setting
    tag = "R7";
    for (int d = 0; d < 4; d++) begin
      rand_low_h();
      dly_sel = 2'(d);
      run_field(16, 90, 40);
    end
    dly_sel = 2'd0;

    // R9: no reference pulse, count holds at the top
    tag = "R9";
    hi_bs = 3'd7; blank_start_lo = 8'd248;
    hi_be = 3'd0; blank_stop_lo  = 8'd5;
    @(negedge clk); href = 1'b1; vsync = 1'b0;
    @(negedge clk); href = 1'b0;
    repeat (2300) @(negedge clk);
    check(hblank_n, 1'b1, "R9", "hblank_n held at top count");

    chk_on = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule